// File: doc/BRIEF.md
# Modulation Level Offset Selector with Rate-Limited Transitions

This block sets the common-mode offset that a dual-inverter open-end winding drive adds to every phase reference before the carrier comparison. The offset decides how many voltage levels the drive uses. At a low modulation index, an offset of one sixth of the total link voltage places the whole reference in the bottom carrier band. Only the smaller inverter then switches, and the phase voltage has two levels. At a higher modulation index, an offset of one half centres the reference across all three carrier bands, which gives four-level operation. A second two-level setting of five sixths is available. In that setting the other bank of legs sits at a fixed rail. The one-third and two-thirds settings produce asymmetric three-level switching, and the block never chooses them as a resting value.

The controller supplies the modulation index and a strobe that fires twice per switching period. The block compares the index with a threshold that has hysteresis, maps the resulting mode to a target offset, and moves its output toward that target by one fixed step per strobe. A full move between one sixth and one half therefore takes two switching periods. A busy flag stays high until the output reaches the target. If the target changes during a ramp, the ramp heads for the new endpoint from wherever it stands.

Top module: `pwm_offset_sel`

## Requirements
- R1: While the level mode is two-level and `alt_two_level` is low, the target offset is 1/6, encoded as 200 (one LSB of `offset` is 1/1200 of the total link voltage). A modulation index at or below 0.35, encoded as 358 or less (one LSB of `mod_index` is 1/1024), selects or keeps two-level mode starting from reset.
- R2: A modulation index above 0.35 (359 or more) switches the mode to four-level on the next clock edge. The target offset is then 1/2, encoded as 600.
- R3: In two-level mode, `alt_two_level` high selects the target 5/6, encoded as 1000. In four-level mode, `alt_two_level` has no effect on the target.
- R4: Once in four-level mode, the block returns to two-level mode only when the index drops to 338 or below. An index between 339 and 358 leaves the mode unchanged.
- R5: `offset` changes only on a clock edge at which `half_strobe` is high. Each change moves it by exactly 100 (1/12) toward the target, and it never passes the target.
- R6: A move between 1/6 and 1/2, or between 1/2 and 5/6, completes in exactly four strobes, which is two switching periods.
- R7: `busy` is high exactly when `offset` differs from the current target. While `busy` is low, strobes leave `offset` unchanged.
- R8: A target change during a ramp takes effect at once. The ramp continues from the present value toward the new target.
- R9: Whenever `busy` is low, `offset` is 200, 600 or 1000. The values 1/3 and 2/3 never appear as a resting value.
- R10: Synchronous reset sets `offset` to 200, selects two-level mode and leaves `busy` low when `alt_two_level` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_index | input | MI_W | Modulation index, unsigned, 1024 = 1.0 |
| half_strobe | input | 1 | One-cycle pulse at each half switching period |
| alt_two_level | input | 1 | Selects 5/6 instead of 1/6 for two-level mode |
| offset | output | OFS_W | Present offset, 1200 = full link voltage |
| busy | output | 1 | High while the offset is moving toward its target |

## Verification
The bench probes the threshold at both 358 and 359. A design that used the wrong comparison at the 0.35 threshold would flip to four-level at exactly 0.35. It then holds the index inside the hysteresis band, where a design without hysteresis would start ramping down. The bench also reverses the ramp halfway. A design that restarted from the old endpoint, or that kept a fixed step count per move, would land on the wrong value or overshoot. Finally, it checks a long stretch without strobes, extra strobes after the target is reached, and the eight-step swap between the two two-level settings. These cases expose a ramp that moves per clock, one that drifts past the target, and an alternate select that still acts in four-level mode.

// File: rtl/pwm_offset_pkg.sv
package pwm_offset_pkg;

    typedef enum logic {
        LVL_TWO  = 1'b0,
        LVL_FOUR = 1'b1
    } lvl_mode_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } ramp_dir_e;

    // Offset values expressed in multiples of one twelfth of the link voltage.
    function automatic int ofs_low(input int twelfth);
        return 2 * twelfth;
    endfunction

    function automatic int ofs_mid(input int twelfth);
        return 6 * twelfth;
    endfunction

    function automatic int ofs_high(input int twelfth);
        return 10 * twelfth;
    endfunction

    function automatic int ofs_target(input lvl_mode_e mode, input logic alt, input int twelfth);
        if (mode == LVL_FOUR) begin
            return ofs_mid(twelfth);
        end
        if (alt) begin
            return ofs_high(twelfth);
        end
        return ofs_low(twelfth);
    endfunction

endpackage

// File: rtl/ofs_mode_hyst.sv
module ofs_mode_hyst
    import pwm_offset_pkg::*;
#(
    parameter int MI_W  = 12,
    parameter int TH_UP = 358,
    parameter int HYST  = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [MI_W-1:0] mod_index,
    output lvl_mode_e       mode
);
    localparam logic [MI_W-1:0] TH_UP_V = MI_W'(TH_UP);
    localparam logic [MI_W-1:0] TH_DN_V = MI_W'(TH_UP - HYST);

    lvl_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= LVL_TWO;
        end else if (mod_index > TH_UP_V) begin
            mode_q <= LVL_FOUR;
        end else if (mod_index <= TH_DN_V) begin
            mode_q <= LVL_TWO;
        end
    end

    assign mode = mode_q;
endmodule

// File: rtl/ofs_target_map.sv
module ofs_target_map
    import pwm_offset_pkg::*;
#(
    parameter int OFS_W   = 11,
    parameter int TWELFTH = 100
) (
    input  lvl_mode_e        mode,
    input  logic             alt_two_level,
    output logic [OFS_W-1:0] target
);
    always_comb begin
        target = OFS_W'(ofs_target(mode, alt_two_level, TWELFTH));
    end
endmodule

// File: rtl/ofs_ramp.sv
module ofs_ramp
    import pwm_offset_pkg::*;
#(
    parameter int OFS_W   = 11,
    parameter int TWELFTH = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic [OFS_W-1:0] target,
    output logic [OFS_W-1:0] offset,
    output logic             busy
);
    localparam logic [OFS_W-1:0] STEP_V  = OFS_W'(TWELFTH);
    localparam logic [OFS_W-1:0] RESET_V = OFS_W'(ofs_low(TWELFTH));

    logic [OFS_W-1:0] ofs_q;
    logic [OFS_W-1:0] ofs_d;
    logic [OFS_W-1:0] gap;
    ramp_dir_e        dir;

    always_comb begin
        if (target > ofs_q) begin
            dir = DIR_UP;
            gap = target - ofs_q;
        end else if (target < ofs_q) begin
            dir = DIR_DOWN;
            gap = ofs_q - target;
        end else begin
            dir = DIR_HOLD;
            gap = '0;
        end
    end

    always_comb begin
        ofs_d = ofs_q;
        if (step_en && dir != DIR_HOLD) begin
            if (gap <= STEP_V) begin
                ofs_d = target;
            end else if (dir == DIR_UP) begin
                ofs_d = ofs_q + STEP_V;
            end else begin
                ofs_d = ofs_q - STEP_V;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q <= RESET_V;
        end else begin
            ofs_q <= ofs_d;
        end
    end

    assign offset = ofs_q;
    assign busy   = (dir != DIR_HOLD);
endmodule

// File: rtl/pwm_offset_sel.sv
module pwm_offset_sel
    import pwm_offset_pkg::*;
#(
    parameter int MI_W    = 12,
    parameter int TH_UP   = 358,
    parameter int HYST    = 20,
    parameter int OFS_W   = 11,
    parameter int TWELFTH = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MI_W-1:0]  mod_index,
    input  logic             half_strobe,
    input  logic             alt_two_level,
    output logic [OFS_W-1:0] offset,
    output logic             busy
);
    lvl_mode_e        cur_mode;
    logic [OFS_W-1:0] target;

    ofs_mode_hyst #(
        .MI_W (MI_W),
        .TH_UP(TH_UP),
        .HYST (HYST)
    ) u_mode (
        .clk      (clk),
        .rst      (rst),
        .mod_index(mod_index),
        .mode     (cur_mode)
    );

    ofs_target_map #(
        .OFS_W  (OFS_W),
        .TWELFTH(TWELFTH)
    ) u_map (
        .mode         (cur_mode),
        .alt_two_level(alt_two_level),
        .target       (target)
    );

    ofs_ramp #(
        .OFS_W  (OFS_W),
        .TWELFTH(TWELFTH)
    ) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .step_en(half_strobe),
        .target (target),
        .offset (offset),
        .busy   (busy)
    );
endmodule

// File: rtl/pwm_offset_sel_chk.sv
module pwm_offset_sel_chk
    import pwm_offset_pkg::*;
#(
    parameter int MI_W    = 12,
    parameter int TH_UP   = 358,
    parameter int HYST    = 20,
    parameter int OFS_W   = 11,
    parameter int TWELFTH = 100
) (
    input logic             clk,
    input logic             rst,
    input logic [MI_W-1:0]  mod_index,
    input logic             half_strobe,
    input logic [OFS_W-1:0] offset,
    input logic             busy,
    input lvl_mode_e        cur_mode
);
    localparam logic [MI_W-1:0]  TH_UP_V = MI_W'(TH_UP);
    localparam logic [MI_W-1:0]  TH_DN_V = MI_W'(TH_UP - HYST);
    localparam logic [OFS_W-1:0] STEP_V  = OFS_W'(TWELFTH);
    localparam logic [OFS_W-1:0] LO_V    = OFS_W'(ofs_low(TWELFTH));
    localparam logic [OFS_W-1:0] MID_V   = OFS_W'(ofs_mid(TWELFTH));
    localparam logic [OFS_W-1:0] HI_V    = OFS_W'(ofs_high(TWELFTH));

    logic [OFS_W-1:0] prev_ofs;
    logic [OFS_W-1:0] moved;

    always_ff @(posedge clk) begin
        prev_ofs <= offset;
    end

    always_comb begin
        moved = (offset > prev_ofs) ? (offset - prev_ofs) : (prev_ofs - offset);
    end

    p_mode_up_r2: assert property (@(posedge clk) disable iff (rst)
        (mod_index > TH_UP_V) |=> (cur_mode == LVL_FOUR));

    p_mode_down_r1: assert property (@(posedge clk) disable iff (rst)
        (mod_index <= TH_DN_V) |=> (cur_mode == LVL_TWO));

    p_band_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mod_index > TH_DN_V && mod_index <= TH_UP_V) |=> $stable(cur_mode));

    p_only_on_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        !half_strobe |=> $stable(offset));

    p_step_size_r5: assert property (@(posedge clk) disable iff (rst)
        (offset != prev_ofs) |-> (moved == STEP_V));

    p_idle_still_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && half_strobe) |=> $stable(offset));

    p_settled_legal_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (offset == LO_V || offset == MID_V || offset == HI_V));
endmodule

bind pwm_offset_sel pwm_offset_sel_chk #(
    .MI_W   (MI_W),
    .TH_UP  (TH_UP),
    .HYST   (HYST),
    .OFS_W  (OFS_W),
    .TWELFTH(TWELFTH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mod_index  (mod_index),
    .half_strobe(half_strobe),
    .offset     (offset),
    .busy       (busy),
    .cur_mode   (cur_mode)
);

// File: tb/pwm_offset_sel_bench.sv
module pwm_offset_sel_bench;
    localparam int MI_W  = 12;
    localparam int OFS_W = 11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [MI_W-1:0]  mod_index = '0;
    logic             half_strobe = 1'b0;
    logic             alt_two_level = 1'b0;
    logic [OFS_W-1:0] offset;
    logic             busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_offset_sel u_pwm_offset_sel (
        .clk          (clk),
        .rst          (rst),
        .mod_index    (mod_index),
        .half_strobe  (half_strobe),
        .alt_two_level(alt_two_level),
        .offset       (offset),
        .busy         (busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse();
        half_strobe = 1'b1;
        @(negedge clk);
        half_strobe = 1'b0;
    endtask

    task automatic set_mi(input int v);
        mod_index = MI_W'(v);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 offset", int'(offset), 200);
        chk("R10 busy", int'(busy), 0);
    endtask

    task automatic t_threshold();
        set_mi(358);
        chk("R1 busy at 0.35", int'(busy), 0);
        pulse();
        chk("R1 offset at 0.35", int'(offset), 200);
    endtask

    task automatic t_up_ramp();
        set_mi(359);
        chk("R7 busy on new target", int'(busy), 1);
        for (int k = 1; k <= 4; k++) begin
            pulse();
            chk("R5 ramp up step", int'(offset), 200 + 100 * k);
            chk("R6 busy during ramp", int'(busy), (k < 4) ? 1 : 0);
        end
        chk("R2 four-level offset", int'(offset), 600);
    endtask

    task automatic t_alt_four();
        alt_two_level = 1'b1;
        @(negedge clk);
        chk("R3 alt ignored busy", int'(busy), 0);
        pulse();
        chk("R3 alt ignored offset", int'(offset), 600);
        alt_two_level = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_hyst();
        set_mi(345);
        pulse();
        chk("R4 band hold 345", int'(offset), 600);
        set_mi(339);
        pulse();
        chk("R4 band hold 339", int'(offset), 600);
        chk("R4 band busy", int'(busy), 0);
        set_mi(338);
        chk("R4 drop busy", int'(busy), 1);
        pulse();
        chk("R4 drop step", int'(offset), 500);
    endtask

    task automatic t_redirect();
        set_mi(500);
        chk("R8 busy after redirect", int'(busy), 1);
        pulse();
        chk("R8 back up", int'(offset), 600);
        chk("R8 settled", int'(busy), 0);
        set_mi(300);
        pulse();
        pulse();
        chk("R8 halfway down", int'(offset), 400);
        set_mi(700);
        pulse();
        chk("R8 reversed from 400", int'(offset), 500);
        pulse();
        chk("R8 end 600", int'(offset), 600);
    endtask

    task automatic t_no_strobe();
        set_mi(100);
        repeat (10) @(negedge clk);
        chk("R5 no strobe hold", int'(offset), 600);
        chk("R7 busy waiting", int'(busy), 1);
        for (int k = 1; k <= 4; k++) begin
            pulse();
            chk("R6 ramp down", int'(offset), 600 - 100 * k);
        end
        chk("R1 low offset", int'(offset), 200);
        chk("R7 idle", int'(busy), 0);
        pulse();
        pulse();
        chk("R5 no overshoot", int'(offset), 200);
    endtask

    task automatic t_alt_two();
        alt_two_level = 1'b1;
        @(negedge clk);
        chk("R3 alt busy", int'(busy), 1);
        for (int k = 1; k <= 8; k++) begin
            pulse();
            chk("R5 alt ramp", int'(offset), 200 + 100 * k);
        end
        chk("R3 alt offset", int'(offset), 1000);
        chk("R9 settled busy", int'(busy), 0);
        set_mi(800);
        for (int k = 1; k <= 4; k++) begin
            pulse();
            chk("R6 from 5/6", int'(offset), 1000 - 100 * k);
        end
        chk("R9 settled mid", int'(busy), 0);
        alt_two_level = 1'b0;
        set_mi(0);
        repeat (4) pulse();
        chk("R1 back to low", int'(offset), 200);
        chk("R9 low settled", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_threshold();
        t_up_ramp();
        t_alt_four();
        t_hyst();
        t_redirect();
        t_no_strobe();
        t_alt_two();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule